// File: doc/BRIEF.md
# Touch and Sensor Conversion Sequencer

This block sequences the conversion cycles of a touch screen and sensor ADC. A host programs a control word that picks the next scan function (a 4-bit code) and a resolution code (2 bits), and enables or disables the sequencer. When the start conditions hold, the sequencer latches the chosen function and resolution. It then stays busy for a fixed number of clock cycles. After that it ORs a function-specific group of bits into an 11-bit data-ready register. The host reads results from a data page. Each read returns the matching sample from the analog front-end inputs, cut to the latched resolution, and clears only the ready bit that belongs to that register.

Two active-low pins leave the block. The pen pin shows one of three selectable sources: the pressure itself, any ready bit set, or pressure while nothing is ready. It is forced inactive while the sequencer is disabled. The ready pin is low whenever any ready bit is set. Some functions are single-shot: once their results are available they turn the sequencer off. Register access uses a command stream (valid/ready). `cmd_ready` is held high, so every command is taken on the cycle its valid is high. A read returns its data on `rsp_valid` one cycle later. The response path has no back-pressure, so the consumer must take it on that cycle.

Top module: `touch_conv_seq`

## Requirements
- R1: Control register (page 1, address 0) write fields: bit 15 host mode, bit 14 = 1 disables (0 enables), bits 13:10 next function, bits 9:8 next resolution code, bits 7:0 filter. Reading it returns bit 15 = pen pressure, bit 14 = not busy, and the other fields in the same positions.
- R2: A conversion starts only when the sequencer is enabled, not busy, and the ready register is zero. Touch functions 1 to 5 also need the pen pressed. Codes 0, 13, 14 and 15 never start a conversion.
- R3: A started conversion is busy for CONV_CYCLES cycles. It then ORs the function's group into the ready register. The groups are: 1→0x600, 2→0x780, 3→0x400, 4→0x200, 5→0x180, 6→0x040, 7→0x030, 8 and 9→0x010, 10→0x004, 11→0x070, 12→0x002.
- R4: While single-shot functions 3, 4, 5, 6, 7, 8, 10 and 12 are selected, the sequencer disables itself once the ready register is nonzero. For 3 to 5 this applies only while the pen is pressed. Functions 1, 2, 9 and 11 stay enabled.
- R5: Writing the control register with bit 14 set while busy aborts the conversion. No ready bits are set and busy clears.
- R6: A data-page read at address i clears only its own ready bit: bit 10−i for i = 0..3, and bit 11−i for i = 5..11. Address 4, and addresses 12 and above, clear nothing and return 0xFFFF.
- R7: A data-page read returns the 16-bit sample shifted right by 16 minus the resolution latched at the last start. Codes 0, 1, 2 and 3 mean 12, 8, 10 and 12 bits.
- R8: `pen_irq_n` is registered, active low and inactive while disabled. The source is selected by status bits 15:14: 0 is pressure, 1 is any ready bit set, 2 and 3 are pressure with no ready bit set.
- R9: `dav_irq_n` is low exactly when the ready register is nonzero.
- R10: Status register (page 1, address 1) reads {source[1:0], disabled, host mode, any-ready, ready[10:0]}. A write changes only the source, from bits 15:14.
- R11: Commands are always accepted. A read gives `rsp_valid` with its data on the following cycle. Control addresses other than 0 and 1 read 0xFFFF. Writes to the data page change nothing.
- R12: After reset, the sequencer is disabled and idle, the ready register is zero, all control fields are zero, the source is 2, both pins are high, and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (held high) |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_page | input | 1 | 0 data page, 1 control page |
| cmd_addr | input | 4 | Register address within the page |
| cmd_wdata | input | 16 | Write value |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 16 | Read data |
| pen_down | input | 1 | Pen pressure from the front-end |
| smp_in | input | 12x16 | Sample per data address, index = address |
| pen_irq_n | output | 1 | Pen interrupt, active low |
| dav_irq_n | output | 1 | Data-ready interrupt, active low |

## Verification
The bench sets CONV_CYCLES to 6 so that each conversion, abort and restart fits in a few dozen cycles. With that setting it can sweep all 16 function codes against both pen states, and all four pin sources against pen, ready and enable states. It also runs every resolution code against several data addresses. The short busy window makes it easy to catch a read during busy and an abort in mid-conversion.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int FUNC_W   = 4;
  localparam int PREC_W   = 2;
  localparam int DAV_W    = 11;
  localparam int SMP_W    = 16;
  localparam int NUM_DATA = 12;
  localparam int ADDR_W   = 4;

  typedef enum logic [1:0] {
    PIN_PRESS       = 2'd0,
    PIN_ANY_DAV     = 2'd1,
    PIN_PRESS_NODAV = 2'd2,
    PIN_ALT         = 2'd3
  } pin_src_e;

  // Ready group that a finished conversion of function f sets.
  function automatic logic [DAV_W-1:0] func_mask(input logic [FUNC_W-1:0] f);
    case (f)
      4'd1:       func_mask = 11'h600;
      4'd2:       func_mask = 11'h780;
      4'd3:       func_mask = 11'h400;
      4'd4:       func_mask = 11'h200;
      4'd5:       func_mask = 11'h180;
      4'd6:       func_mask = 11'h040;
      4'd7:       func_mask = 11'h030;
      4'd8, 4'd9: func_mask = 11'h010;
      4'd10:      func_mask = 11'h004;
      4'd11:      func_mask = 11'h070;
      4'd12:      func_mask = 11'h002;
      default:    func_mask = '0;
    endcase
  endfunction

  function automatic logic is_touch(input logic [FUNC_W-1:0] f);
    is_touch = (f >= 4'd1) && (f <= 4'd5);
  endfunction

  function automatic logic is_single(input logic [FUNC_W-1:0] f);
    case (f)
      4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd10, 4'd12: is_single = 1'b1;
      default: is_single = 1'b0;
    endcase
  endfunction

  function automatic int res_bits(input int p);
    case (p)
      1:       res_bits = 8;
      2:       res_bits = 10;
      default: res_bits = 12;
    endcase
  endfunction

  // Ready bit owned by data address a (one-hot, zero if none).
  function automatic logic [DAV_W-1:0] addr_dav_bit(input logic [ADDR_W-1:0] a);
    addr_dav_bit = '0;
    if (a < 4'd4)
      addr_dav_bit[4'd10 - a] = 1'b1;
    else if (a > 4'd4 && a < 4'(NUM_DATA))
      addr_dav_bit[4'd11 - a] = 1'b1;
  endfunction
endpackage

// File: rtl/tcs_seq_core.sv
module tcs_seq_core
  import tcs_pkg::*;
#(
  parameter int CONV_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              ctrl_en,
  input  logic [FUNC_W-1:0] next_func,
  input  logic [PREC_W-1:0] next_prec,
  input  logic              pen,
  input  logic [DAV_W-1:0]  dav_clr,
  output logic              enabled,
  output logic              busy,
  output logic [PREC_W-1:0] prec_q,
  output logic [DAV_W-1:0]  dav
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);

  logic [CNT_W-1:0]  cnt;
  logic [FUNC_W-1:0] func_q;
  logic abort, pen_ok, start, expire, ss_stop;

  assign abort   = ctrl_we && !ctrl_en;
  assign pen_ok  = !is_touch(next_func) || pen;
  assign start   = enabled && !busy && (dav == '0) && !abort &&
                   (func_mask(next_func) != '0) && pen_ok;
  assign expire  = busy && (cnt == '0) && !abort;
  assign ss_stop = enabled && is_single(next_func) && pen_ok && (dav != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      func_q  <= '0;
      prec_q  <= '0;
      dav     <= '0;
    end else begin
      if (ctrl_we)      enabled <= ctrl_en;
      else if (ss_stop) enabled <= 1'b0;

      if (abort) begin
        busy <= 1'b0;
      end else if (start) begin
        busy   <= 1'b1;
        cnt    <= CNT_W'(CONV_CYCLES - 1);
        func_q <= next_func;
        prec_q <= next_prec;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end

      dav <= (dav & ~dav_clr) | (expire ? func_mask(func_q) : '0);
    end
  end

  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0 && !abort) |=> busy);
  a_r3_done_sets_dav: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == '0 && !abort) |=> (dav != '0));
  a_r2_no_start_with_dav: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && dav != '0) |=> !busy);
  a_r5_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !enabled));
  a_r4_single_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_we && enabled && dav != '0 && is_single(next_func) && pen_ok) |=> !enabled);
endmodule

// File: rtl/tcs_trunc.sv
module tcs_trunc
  import tcs_pkg::*;
(
  input  logic [SMP_W-1:0]  sample,
  input  logic [PREC_W-1:0] prec,
  output logic [SMP_W-1:0]  result
);
  localparam int NPREC = 1 << PREC_W;

  logic [NPREC-1:0][SMP_W-1:0] shifted;

  for (genvar p = 0; p < NPREC; p++) begin : g_res
    localparam int SH = SMP_W - res_bits(p);
    assign shifted[p] = sample >> SH;
  end

  assign result = shifted[prec];

  always_comb begin
    a_r7_width_bound: assert (result < (SMP_W'(1) << 12));
  end
endmodule

// File: rtl/tcs_pen_pin.sv
module tcs_pen_pin
  import tcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     pen,
  input  logic     dav_any,
  input  pin_src_e src,
  output logic     pen_irq_n
);
  logic active;

  always_comb begin
    case (src)
      PIN_PRESS:   active = pen;
      PIN_ANY_DAV: active = dav_any;
      default:     active = pen && !dav_any;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pen_irq_n <= 1'b1;
    else        pen_irq_n <= !(en && active);
  end

  a_r8_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pen_irq_n);
endmodule

// File: rtl/touch_conv_seq.sv
module touch_conv_seq
  import tcs_pkg::*;
#(
  parameter int CONV_CYCLES = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cmd_valid,
  output logic                             cmd_ready,
  input  logic                             cmd_write,
  input  logic                             cmd_page,
  input  logic [ADDR_W-1:0]                cmd_addr,
  input  logic [15:0]                      cmd_wdata,
  output logic                             rsp_valid,
  output logic [15:0]                      rsp_data,
  input  logic                             pen_down,
  input  logic [NUM_DATA-1:0][SMP_W-1:0]   smp_in,
  output logic                             pen_irq_n,
  output logic                             dav_irq_n
);
  logic              host_mode;
  logic [FUNC_W-1:0] next_func;
  logic [PREC_W-1:0] next_prec;
  logic [7:0]        filter;
  pin_src_e          pin_src;

  logic enabled, busy;
  logic [PREC_W-1:0] prec_q;
  logic [DAV_W-1:0]  dav, dav_clr;
  logic [SMP_W-1:0]  sel_smp, trunc_smp;
  logic [15:0]       rd_val;

  logic wr, rd, ctrl0_we, stat_we;

  assign cmd_ready = 1'b1;
  assign wr        = cmd_valid && cmd_write;
  assign rd        = cmd_valid && !cmd_write;
  assign ctrl0_we  = wr && cmd_page && (cmd_addr == 4'd0);
  assign stat_we   = wr && cmd_page && (cmd_addr == 4'd1);
  assign dav_clr   = (rd && !cmd_page) ? addr_dav_bit(cmd_addr) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_mode <= 1'b0;
      next_func <= '0;
      next_prec <= '0;
      filter    <= '0;
      pin_src   <= PIN_PRESS_NODAV;
    end else begin
      if (ctrl0_we) begin
        host_mode <= cmd_wdata[15];
        next_func <= cmd_wdata[13:10];
        next_prec <= cmd_wdata[9:8];
        filter    <= cmd_wdata[7:0];
      end
      if (stat_we) pin_src <= pin_src_e'(cmd_wdata[15:14]);
    end
  end

  tcs_seq_core #(.CONV_CYCLES(CONV_CYCLES)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl0_we),
    .ctrl_en   (!cmd_wdata[14]),
    .next_func (next_func),
    .next_prec (next_prec),
    .pen       (pen_down),
    .dav_clr   (dav_clr),
    .enabled   (enabled),
    .busy      (busy),
    .prec_q    (prec_q),
    .dav       (dav)
  );

  assign sel_smp = (cmd_addr < ADDR_W'(NUM_DATA)) ? smp_in[cmd_addr] : '0;

  tcs_trunc u_trunc (
    .sample (sel_smp),
    .prec   (prec_q),
    .result (trunc_smp)
  );

  tcs_pen_pin u_pen (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (enabled),
    .pen       (pen_down),
    .dav_any   (dav != '0),
    .src       (pin_src),
    .pen_irq_n (pen_irq_n)
  );

  assign dav_irq_n = (dav == '0);

  always_comb begin
    rd_val = 16'hFFFF;
    if (!cmd_page) begin
      if (cmd_addr != 4'd4 && cmd_addr < ADDR_W'(NUM_DATA)) rd_val = trunc_smp;
    end else begin
      case (cmd_addr)
        4'd0: rd_val = {pen_down, !busy, next_func, next_prec, filter};
        4'd1: rd_val = {pin_src, !enabled, host_mode, dav != '0, dav};
        default: rd_val = 16'hFFFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_data <= rd_val;
    end
  end

  a_r11_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid && !cmd_write));
  a_r6_read_clears_own: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !cmd_page && cmd_addr == 4'd0 && !busy) |=> !dav[10]);
  a_r9_dav_pin_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dav_clr == '0 && !busy && dav != '0) |-> !dav_irq_n);
endmodule

// File: tb/test_touch_conv_seq.sv
module test_touch_conv_seq;
  localparam int CONV = 6;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_write = 0, cmd_page = 0;
  logic [3:0] cmd_addr = 0;
  logic [15:0] cmd_wdata = 0;
  logic cmd_ready, rsp_valid, pen_irq_n, dav_irq_n;
  logic [15:0] rsp_data;
  logic pen_down = 0;
  logic [11:0][15:0] smp_in;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  touch_conv_seq #(.CONV_CYCLES(CONV)) i_touch_conv_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_page(cmd_page), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pen_down(pen_down), .smp_in(smp_in), .pen_irq_n(pen_irq_n),
    .dav_irq_n(dav_irq_n));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic pg, input logic [3:0] a, input logic [15:0] d);
    cmd_valid = 1; cmd_write = 1; cmd_page = pg; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0; cmd_write = 0;
  endtask

  task automatic rd(input logic pg, input logic [3:0] a, output logic [15:0] d);
    cmd_valid = 1; cmd_write = 0; cmd_page = pg; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 0;
    n_chk++;
    if (rsp_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R11: actual rsp_valid %b expected 1", rsp_valid);
    end
    d = rsp_data;
  endtask

  function automatic logic [10:0] exp_mask(input int f);
    case (f)
      1: return 11'h600;  2: return 11'h780;  3: return 11'h400;
      4: return 11'h200;  5: return 11'h180;  6: return 11'h040;
      7: return 11'h030;  8: return 11'h010;  9: return 11'h010;
      10: return 11'h004; 11: return 11'h070; 12: return 11'h002;
      default: return 11'h000;
    endcase
  endfunction

  function automatic int exp_res(input int p);
    return (p == 1) ? 8 : (p == 2) ? 10 : 12;
  endfunction

  // Disable and drain every ready bit.
  task automatic clear_all();
    logic [15:0] d;
    wr(1, 0, 16'h4000);
    for (int a = 0; a < 12; a++) rd(0, 4'(a), d);
  endtask

  initial begin
    for (int k = 0; k < 12; k++) smp_in[k] = 16'hF00D ^ 16'(k * 16'h1357);
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, v0;
    idle(3);
    // R12 reset state
    check("R12 rsp_valid", {15'd0, rsp_valid}, 16'd0);
    check("R12 pen_irq_n", {15'd0, pen_irq_n}, 16'd1);
    check("R12 dav_irq_n", {15'd0, dav_irq_n}, 16'd1);
    rst_n = 1;
    idle(2);
    check("R12 cmd_ready", {15'd0, cmd_ready}, 16'd1);
    rd(1, 0, d); check("R12 ctrl", d, 16'h4000);
    rd(1, 1, d); check("R12 status", d, 16'hA000);

    // R1 field layout, R10 host mode bit
    pen_down = 1;
    wr(1, 0, 16'h8000 | 16'h4000 | (16'd13 << 10) | (16'd2 << 8) | 16'h5A);
    rd(1, 0, d); check("R1 ctrl readback", d, 16'h8000 | 16'h4000 | (16'd13 << 10) | (16'd2 << 8) | 16'h5A);
    rd(1, 1, d); check("R10 status host", d, 16'hB000);
    pen_down = 0;
    wr(1, 0, 16'h4000);

    // R11 unmapped reads and ignored data-page writes
    rd(1, 5, d); check("R11 unmapped ctrl", d, 16'hFFFF);
    rd(0, 4, d); check("R6 data addr 4", d, 16'hFFFF);
    rd(0, 13, d); check("R6 data addr 13", d, 16'hFFFF);
    wr(0, 0, 16'h1234);
    rd(1, 1, d); check("R11 data write ignored", d, 16'hA000);

    // R2 R3 R4 R9: sweep all function codes against pen state
    for (int p = 0; p < 2; p++) begin
      for (int f = 0; f < 16; f++) begin
        logic [10:0] m;
        logic runs, touch, single, en_after;
        pen_down = p[0];
        clear_all();
        touch  = (f >= 1 && f <= 5);
        single = (f inside {3, 4, 5, 6, 7, 8, 10, 12});
        runs   = (exp_mask(f) != 0) && (!touch || p == 1);
        m      = runs ? exp_mask(f) : 11'h0;
        en_after = !(runs && single);
        wr(1, 0, 16'(f) << 10);
        if (runs) begin
          idle(1);
          rd(1, 0, d); check("R3 busy during conversion", {15'd0, d[14]}, 16'd0);
        end
        idle(CONV + 6);
        rd(1, 1, d);
        check($sformatf("R3 dav f=%0d pen=%0d", f, p), {5'd0, d[10:0]}, {5'd0, m});
        check($sformatf("R4 enable f=%0d pen=%0d", f, p), {15'd0, d[13]}, {15'd0, !en_after});
        check($sformatf("R9 dav pin f=%0d", f), {15'd0, dav_irq_n}, {15'd0, m == 0});
      end
    end

    // R6 own-bit clearing with XYZ scan
    pen_down = 1;
    clear_all();
    wr(1, 0, 16'd2 << 10);
    idle(CONV + 6);
    rd(0, 1, d); rd(1, 1, d); check("R6 clear Y", {5'd0, d[10:0]}, 16'h580);
    rd(0, 3, d); rd(1, 1, d); check("R6 clear Z2", {5'd0, d[10:0]}, 16'h500);
    rd(0, 4, d); rd(1, 1, d); check("R6 addr 4 no clear", {5'd0, d[10:0]}, 16'h500);
    rd(0, 0, d); rd(1, 1, d); check("R6 clear X", {5'd0, d[10:0]}, 16'h100);

    // R2 R4: dav set blocks start, single-shot then disables
    pen_down = 0;
    clear_all();
    wr(1, 0, 16'd9 << 10);
    idle(CONV + 6);
    rd(1, 1, d); check("R4 continuous stays on", d[13:0], {3'b000, 11'h010} | 14'h0800);
    wr(1, 0, 16'd6 << 10);
    idle(CONV + 6);
    rd(1, 1, d); check("R2 blocked by dav", d[13:0], {3'b100, 11'h010} | 14'h0800);

    // R5 abort
    clear_all();
    wr(1, 0, 16'd6 << 10);
    idle(2);
    wr(1, 0, 16'h4000 | (16'd6 << 10));
    idle(CONV + 6);
    rd(1, 1, d); check("R5 abort no dav", {5'd0, d[10:0]}, 16'h0);
    rd(1, 0, d); check("R5 abort not busy", {15'd0, d[14]}, 16'd1);

    // R7 truncation for every resolution code, latched at start
    for (int pr = 0; pr < 4; pr++) begin
      clear_all();
      wr(1, 0, (16'd6 << 10) | 16'(pr << 8));
      idle(CONV + 6);
      for (int a = 0; a < 12; a += 5) begin
        rd(0, 4'(a), d);
        check($sformatf("R7 prec=%0d addr=%0d", pr, a), d, smp_in[a] >> (16 - exp_res(pr)));
      end
      v0 = smp_in[5] >> (16 - exp_res(pr));
      wr(1, 0, 16'h4000 | 16'(((pr + 1) % 4) << 8));
      rd(0, 5, d); check($sformatf("R7 latched prec=%0d", pr), d, v0);
    end

    // R8 pen pin sources x pen x dav, R10 source write
    for (int s = 0; s < 4; s++) begin
      for (int dv = 0; dv < 2; dv++) begin
        for (int p = 0; p < 2; p++) begin
          logic src;
          pen_down = 0;
          clear_all();
          wr(1, 1, 16'(s << 14) | 16'h3FFF);
          wr(1, 0, dv ? (16'd9 << 10) : 16'h0000);
          idle(CONV + 6);
          pen_down = p[0];
          idle(2);
          src = (s == 0) ? p[0] : (s == 1) ? dv[0] : (p[0] && !dv[0]);
          check($sformatf("R8 src=%0d dav=%0d pen=%0d", s, dv, p), {15'd0, pen_irq_n}, {15'd0, !src});
          rd(1, 1, d); check("R10 source field", {14'd0, d[15:14]}, 16'(s));
          wr(1, 0, 16'h4000 | (dv ? (16'd9 << 10) : 16'h0));
          idle(2);
          check("R8 forced off when disabled", {15'd0, pen_irq_n}, 16'd1);
        end
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule